// File: doc/BRIEF.md
# Indirect Dword Register Window

This block gives a host a narrow eight-byte window onto a larger byte-addressed register file. The host picks a dword number with a one-byte selector and then reads or writes a 32-bit data field. The data field mirrors the file bytes at offset selector×4. A write that lands on the data field is passed to those four file bytes. Each file byte has its own writable bits, write-one-to-clear bits and read-only bits.

Host accesses are one to four bytes wide and little-endian, and they start at any byte of the window. After any write to the window, the data field is loaded again from the file, so the data field always matches the file. The window also holds a two-byte header and a read-only status byte. File bytes at or past the end of the file do not exist: writes to them are dropped and they read as zero. The file holds one byte that acts as a command byte. A forwarded write that covers it raises a one-cycle trigger and presents the new byte value.

Accesses must be at least four cycles apart. The forward step and the reload step take two clocks after a write, and read data is registered.

Top module: `dword_window`

## Requirements
- R1: After reset, window byte 0 reads HDR_ID, byte 1 reads HDR_NEXT, the selector (byte 2) reads 0 and byte 3 reads STAT_VAL. The data field (bytes 4..7) reads file bytes 0..3. The reset value of file byte i is RST_SEED + 29·i, kept to 8 bits.
- R2: All 8 bits of the selector at window byte 2 are writable. Host writes leave window bytes 0, 1 and 3 unchanged.
- R3: A host access covers cfg_size bytes, from 1 to 4, starting at cfg_addr. Lane k of cfg_wdata and cfg_rdata maps to window byte cfg_addr+k. Lanes that would fall at window byte 8 or beyond are dropped on write and read as zero.
- R4: A write that touches any of window bytes 4..7 is forwarded to file bytes selector×4+k, where k is 0..3. Each byte takes new = ((old & ~wm) | (v & wm)) & ~(v & wc), with v the data-field byte after the host write. The masks follow i mod 4: for 0, wm=FF and wc=00; for 1, wm=0F and wc=F0; for 2, wm=00 and wc=FF; for 3, wm=00 and wc=00.
- R5: Writing a one to a write-one-to-clear bit clears that bit. Writing a zero to it leaves the bit unchanged.
- R6: Bits whose wm and wc are both zero keep their value through any forwarded write.
- R7: File bytes at index FILE_BYTES or above are ignored on write and read as zero. A dword that straddles the end is truncated, so its lower bytes still work.
- R8: Every host write, including one that touches only the selector or a read-only byte, reloads the data field from file bytes selector×4..+3 within two clocks. A read made after that returns the reloaded value.
- R9: When a forwarded write covers file byte CMD_OFS, cmd_fire is high for exactly one cycle and cmd_byte carries that byte's new value. No other write raises cmd_fire.
- R10: cfg_rdata changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 3 | Window byte offset of the access |
| cfg_size | input | 3 | Access width in bytes (1..4) |
| cfg_we | input | 1 | Write request, one cycle |
| cfg_re | input | 1 | Read request, one cycle |
| cfg_wdata | input | 32 | Write data, lane k goes to byte cfg_addr+k |
| cfg_rdata | output | 32 | Registered read data |
| cmd_fire | output | 1 | One-cycle pulse when the command byte is written |
| cmd_byte | output | 8 | New value of the command byte |

## Verification
The bench builds the block with FILE_BYTES=38, CMD_OFS=20, RST_SEED=0x11 and a status value of 0x5A. With 38 bytes the file ends inside dword 9. Sweeping the selector from 0 to 12 therefore covers fully present dwords, the truncated dword and absent dwords. Every dword holds one byte of each of the four mask classes, so every pattern written meets writable, split, clear-on-one and read-only bits together. All start offsets and widths of host access in the window are applied against an arithmetic model. The model also predicts every command-byte pulse.

// File: rtl/dword_window_pkg.sv
`timescale 1ns/1ps
package dword_window_pkg;
  localparam int WIN_BYTES = 8;
  localparam int HDR0_POS  = 0;
  localparam int HDR1_POS  = 1;
  localparam int SEL_POS   = 2;
  localparam int STAT_POS  = 3;
  localparam int DATA_POS  = 4;
  localparam int LANES     = 4;

  typedef enum logic [1:0] {
    BK_RW    = 2'd0,
    BK_SPLIT = 2'd1,
    BK_CLR   = 2'd2,
    BK_RO    = 2'd3
  } byte_kind_e;

  function automatic byte_kind_e kind_of(int idx);
    return byte_kind_e'(2'(idx % 4));
  endfunction

  function automatic logic [7:0] wmask_of(int idx);
    case (kind_of(idx))
      BK_RW:    return 8'hFF;
      BK_SPLIT: return 8'h0F;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] w1c_of(int idx);
    case (kind_of(idx))
      BK_SPLIT: return 8'hF0;
      BK_CLR:   return 8'hFF;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_of(int idx, logic [7:0] seed);
    return seed + 8'(idx * 29);
  endfunction

  function automatic logic [7:0] merge_byte(logic [7:0] old, logic [7:0] v,
                                            logic [7:0] wm, logic [7:0] wc);
    return ((old & ~wm) | (v & wm)) & ~(v & wc);
  endfunction

  function automatic logic lane_live(logic [2:0] addr, logic [2:0] size, int k);
    return (k < int'(size)) && (int'(addr) + k < WIN_BYTES);
  endfunction

  function automatic logic [31:0] init_dword(logic [7:0] seed, int nbytes);
    logic [31:0] v = '0;
    for (int k = 0; k < LANES; k++)
      if (k < nbytes) v[8*k +: 8] = rst_of(k, seed);
    return v;
  endfunction
endpackage

// File: rtl/dword_window_regs.sv
`timescale 1ns/1ps
module dword_window_regs
  import dword_window_pkg::*;
#(
  parameter logic [7:0]  HDR_ID    = 8'h0C,
  parameter logic [7:0]  HDR_NEXT  = 8'h48,
  parameter logic [7:0]  STAT_VAL  = 8'h5A,
  parameter logic [31:0] DATA_INIT = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic [2:0]  size,
  input  logic        we,
  input  logic        re,
  input  logic [31:0] wdata,
  input  logic        reload_go,
  input  logic [31:0] reload_data,
  output logic [7:0]  sel_q,
  output logic [31:0] data_q,
  output logic [31:0] rdata_q,
  output logic        hit_data
);
  localparam int WIN_BITS = WIN_BYTES * 8;

  logic [WIN_BYTES-1:0] win_we;
  logic [WIN_BITS-1:0]  win_wv;
  logic [WIN_BITS-1:0]  win_v;
  logic [31:0]          rd_v;

  // Byte enables and byte values per window position
  always_comb begin
    win_we = '0;
    win_wv = '0;
    for (int k = 0; k < LANES; k++) begin
      if (we && lane_live(addr, size, k)) begin
        win_we[int'(addr) + k]          = 1'b1;
        win_wv[8*(int'(addr) + k) +: 8] = wdata[8*k +: 8];
      end
    end
  end

  assign hit_data = |win_we[WIN_BYTES-1:DATA_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 8'h00;
      data_q <= DATA_INIT;
    end else begin
      if (reload_go) data_q <= reload_data;
      if (win_we[SEL_POS]) sel_q <= win_wv[8*SEL_POS +: 8];
      for (int p = DATA_POS; p < WIN_BYTES; p++)
        if (win_we[p]) data_q[8*(p-DATA_POS) +: 8] <= win_wv[8*p +: 8];
    end
  end

  // Readable image of the window
  always_comb begin
    win_v = '0;
    win_v[8*HDR0_POS +: 8] = HDR_ID;
    win_v[8*HDR1_POS +: 8] = HDR_NEXT;
    win_v[8*SEL_POS  +: 8] = sel_q;
    win_v[8*STAT_POS +: 8] = STAT_VAL;
    win_v[8*DATA_POS +: 32] = data_q;
  end

  always_comb begin
    rd_v = '0;
    for (int k = 0; k < LANES; k++)
      if (lane_live(addr, size, k))
        rd_v[8*k +: 8] = win_v[8*(int'(addr) + k) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= rd_v;
  end
endmodule

// File: rtl/dword_window_seq.sv
`timescale 1ns/1ps
module dword_window_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic hit_data,
  output logic fwd_go,
  output logic reload_go
);
  logic s1_q, s1_fwd_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s1_fwd_q <= 1'b0;
      s2_q     <= 1'b0;
    end else begin
      s1_q     <= we;
      s1_fwd_q <= we && hit_data;
      s2_q     <= s1_q;
    end
  end

  // Stage 1 commits the file write, stage 2 refreshes the data field
  assign fwd_go    = s1_q && s1_fwd_q;
  assign reload_go = s2_q;
endmodule

// File: rtl/dword_window_file.sv
`timescale 1ns/1ps
module dword_window_file
  import dword_window_pkg::*;
#(
  parameter int         FILE_BYTES = 38,
  parameter int         CMD_OFS    = 20,
  parameter logic [7:0] RST_SEED   = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fwd_go,
  input  logic [7:0]  sel,
  input  logic [31:0] wr_data,
  output logic [31:0] reload_data,
  output logic        cmd_fire,
  output logic [7:0]  cmd_byte
);
  logic [7:0] bytes_q [FILE_BYTES];

  // Masked forwarded write; bytes past the end have no storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FILE_BYTES; i++) bytes_q[i] <= rst_of(i, RST_SEED);
    end else if (fwd_go) begin
      for (int i = 0; i < FILE_BYTES; i++)
        if (i / 4 == int'(sel))
          bytes_q[i] <= merge_byte(bytes_q[i], wr_data[8*(i%4) +: 8],
                                   wmask_of(i), w1c_of(i));
    end
  end

  // Refresh path; absent bytes read as zero
  always_comb begin
    reload_data = '0;
    for (int i = 0; i < FILE_BYTES; i++)
      if (i / 4 == int'(sel)) reload_data[8*(i%4) +: 8] = bytes_q[i];
  end

  generate
    if (CMD_OFS >= 0 && CMD_OFS < FILE_BYTES) begin : g_cmd
      logic       fire_q;
      logic [7:0] byte_q;
      logic       cmd_hit;
      assign cmd_hit = fwd_go && (CMD_OFS / 4 == int'(sel));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fire_q <= 1'b0;
          byte_q <= 8'h00;
        end else begin
          fire_q <= cmd_hit;
          if (cmd_hit)
            byte_q <= merge_byte(bytes_q[CMD_OFS], wr_data[8*(CMD_OFS%4) +: 8],
                                 wmask_of(CMD_OFS), w1c_of(CMD_OFS));
        end
      end
      assign cmd_fire = fire_q;
      assign cmd_byte = byte_q;
    end else begin : g_nocmd
      assign cmd_fire = 1'b0;
      assign cmd_byte = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/dword_window.sv
`timescale 1ns/1ps
module dword_window
  import dword_window_pkg::*;
#(
  parameter int         FILE_BYTES = 38,
  parameter int         CMD_OFS    = 20,
  parameter logic [7:0] RST_SEED   = 8'h11,
  parameter logic [7:0] HDR_ID     = 8'h0C,
  parameter logic [7:0] HDR_NEXT   = 8'h48,
  parameter logic [7:0] STAT_VAL   = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_addr,
  input  logic [2:0]  cfg_size,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cmd_fire,
  output logic [7:0]  cmd_byte
);
  localparam logic [31:0] DATA_INIT = init_dword(RST_SEED, FILE_BYTES);

  logic [7:0]  sel_q;
  logic [31:0] data_q;
  logic [31:0] reload_data;
  logic        hit_data;
  logic        fwd_go;
  logic        reload_go;

  dword_window_regs #(
    .HDR_ID(HDR_ID), .HDR_NEXT(HDR_NEXT), .STAT_VAL(STAT_VAL), .DATA_INIT(DATA_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(cfg_addr), .size(cfg_size), .we(cfg_we), .re(cfg_re), .wdata(cfg_wdata),
    .reload_go(reload_go), .reload_data(reload_data),
    .sel_q(sel_q), .data_q(data_q), .rdata_q(cfg_rdata), .hit_data(hit_data)
  );

  dword_window_seq u_seq (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .hit_data(hit_data),
    .fwd_go(fwd_go), .reload_go(reload_go)
  );

  dword_window_file #(
    .FILE_BYTES(FILE_BYTES), .CMD_OFS(CMD_OFS), .RST_SEED(RST_SEED)
  ) u_file (
    .clk(clk), .rst_n(rst_n), .fwd_go(fwd_go), .sel(sel_q), .wr_data(data_q),
    .reload_data(reload_data), .cmd_fire(cmd_fire), .cmd_byte(cmd_byte)
  );
endmodule

// File: rtl/dword_window_chk.sv
`timescale 1ns/1ps
module dword_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_re,
  input logic [31:0] cfg_rdata,
  input logic        cmd_fire,
  input logic [7:0]  sel_q,
  input logic [31:0] data_q,
  input logic        fwd_go,
  input logic        reload_go
);
  // R4
  fwd_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_go |-> $past(cfg_we));

  // R8
  reload_two_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |-> $past(cfg_we, 2));

  // R8
  data_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> ($past(cfg_we) || $past(reload_go)));

  // R2
  sel_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(cfg_we));

  // R9
  cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);

  // R9
  cmd_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> $past(fwd_go));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rdata) |-> $past(cfg_re));
endmodule

bind dword_window dword_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
  .cmd_fire(cmd_fire), .sel_q(sel_q), .data_q(data_q),
  .fwd_go(fwd_go), .reload_go(reload_go)
);

// File: tb/tb_dword_window.sv
`timescale 1ns/1ps
module tb_dword_window;
  localparam int         FB   = 38;
  localparam int         CMDB = 20;
  localparam logic [7:0] SEED = 8'h11;
  localparam logic [7:0] HID  = 8'h0C;
  localparam logic [7:0] HNX  = 8'h48;
  localparam logic [7:0] STV  = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [2:0]  cfg_size = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_re = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_fire;
  logic [7:0]  cmd_byte;

  int n_vec = 0;
  int n_bad = 0;
  int obs_pulses = 0;
  int exp_pulses = 0;
  logic [7:0] exp_cmd = 8'h00;

  logic [7:0]  m_file [FB];
  logic [7:0]  m_sel;
  logic [31:0] m_data;

  always #2.5 clk = ~clk;

  dword_window #(
    .FILE_BYTES(FB), .CMD_OFS(CMDB), .RST_SEED(SEED),
    .HDR_ID(HID), .HDR_NEXT(HNX), .STAT_VAL(STV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmd_fire(cmd_fire), .cmd_byte(cmd_byte)
  );

  always @(negedge clk) if (rst_n && cmd_fire) obs_pulses++;

  function automatic logic [7:0] m_wm(int i);
    if (i % 4 == 0) return 8'hFF;
    if (i % 4 == 1) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_wc(int i);
    if (i % 4 == 1) return 8'hF0;
    if (i % 4 == 2) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [31:0] m_fetch(logic [7:0] s);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) begin
      int b = int'(s) * 4 + k;
      if (b < FB) v[8*k +: 8] = m_file[b];
    end
    return v;
  endfunction

  function automatic logic [7:0] m_win(int p);
    case (p)
      0: return HID;
      1: return HNX;
      2: return m_sel;
      3: return STV;
      default: return m_data[8*(p-4) +: 8];
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int sz, input logic [31:0] v);
    bit touched = 0;
    for (int k = 0; k < 4; k++) begin
      if (k < sz && a + k < 8) begin
        if (a + k == 2) m_sel = v[8*k +: 8];
        if (a + k >= 4) begin
          m_data[8*(a+k-4) +: 8] = v[8*k +: 8];
          touched = 1;
        end
      end
    end
    if (touched) begin
      for (int k = 0; k < 4; k++) begin
        int b = int'(m_sel) * 4 + k;
        if (b < FB) begin
          logic [7:0] nv;
          nv = ((m_file[b] & ~m_wm(b)) | (m_data[8*k +: 8] & m_wm(b)))
               & ~(m_data[8*k +: 8] & m_wc(b));
          m_file[b] = nv;
          if (b == CMDB) begin
            exp_pulses++;
            exp_cmd = nv;
          end
        end
      end
    end
    m_data = m_fetch(m_sel);
    @(negedge clk);
    cfg_addr = 3'(a); cfg_size = 3'(sz); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    // R9: pulse count and command value after every write
    check(32'(obs_pulses), 32'(exp_pulses), "R9 cmd_fire cycle count");
    if (exp_pulses > 0) check({24'h0, cmd_byte}, {24'h0, exp_cmd}, "R9 cmd_byte");
  endtask

  task automatic rd(input int a, input int sz, input string what);
    logic [31:0] e = '0;
    for (int k = 0; k < 4; k++)
      if (k < sz && a + k < 8) e[8*k +: 8] = m_win(a + k);
    @(negedge clk);
    cfg_addr = 3'(a); cfg_size = 3'(sz); cfg_re = 1'b1;
    @(negedge clk);
    cfg_re = 1'b0;
    check(cfg_rdata, e, what);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < FB; i++) m_file[i] = SEED + 8'(i * 29);
    m_sel  = 8'h00;
    m_data = m_fetch(8'h00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset image
    rd(0, 4, "R1 header/selector/status after reset");
    rd(4, 4, "R1 data field after reset");
    check({31'h0, cmd_fire}, 32'h0, "R1 cmd_fire idle");

    // R8 and R7: selector sweep past the end of the file
    for (int s = 0; s < 13; s++) begin
      wr(2, 1, 32'(s));
      rd(2, 1, "R2 selector readback");
      rd(4, 4, (s >= 9) ? "R7 reload at or past end" : "R8 reload after selector write");
    end

    // R2: header and status are read-only; write still refreshes (R8)
    wr(2, 1, 32'h1);
    wr(0, 2, 32'h0000_A5A5);
    rd(0, 2, "R2 header unchanged");
    wr(3, 1, 32'h0000_00FF);
    rd(3, 1, "R2 status unchanged");
    rd(4, 4, "R8 data after header write");

    // R4 R5 R6 R7: three patterns through every dword
    for (int s = 0; s < 11; s++) begin
      logic [31:0] pat;
      pat = {8'(s*5+8'hC3), 8'(s*3+8'h81), 8'(s*7+8'h40), 8'(s*13+1)};
      wr(2, 1, 32'(s));
      wr(4, 4, pat);
      rd(4, 4, (s >= 9) ? "R7 forwarded write truncated" : "R4 forwarded merge");
      wr(4, 4, 32'h0000_0000);
      rd(4, 4, "R5 zeros leave clear bits");
      wr(4, 4, 32'hFFFF_FFFF);
      rd(4, 4, "R6 read-only bits kept, R5 ones clear");
    end

    // R3: every start offset and width
    for (int a = 0; a < 8; a++) begin
      for (int sz = 1; sz <= 4; sz++) begin
        logic [31:0] v;
        v = {8'(a*17+sz), 8'(a*3+8'h90), 8'(sz*11+8'h20), 8'(a+sz*2)};
        if (a <= 2 && a + sz > 2) v[8*(2-a) +: 8] = 8'(a + sz);
        wr(a, sz, v);
        rd(a, sz, "R3 partial access");
        rd(4, 4, "R3 data after partial write");
      end
    end

    // R9: command byte in dword 5, lane 0
    wr(2, 1, 32'(CMDB / 4));
    wr(4, 1, 32'h0000_0077);
    wr(5, 1, 32'h0000_0003);
    wr(2, 1, 32'h3);
    wr(4, 4, 32'h1234_5678);

    // R10: read data holds across writes
    begin
      logic [31:0] held;
      rd(0, 4, "R10 read before hold");
      held = cfg_rdata;
      wr(2, 1, 32'h2);
      wr(4, 4, 32'hDEAD_BEEF);
      check(cfg_rdata, held, "R10 rdata held without read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule